// File: doc/BRIEF.md
# Watchdog Limit Compare and Interrupt Status

This block watches conversion results produced while the converter's sequencer runs in watchdog mode. Each watchdog instruction carries two limit words. Each limit has its own direction bit that makes it a floor or a ceiling, so a pair of floors or a pair of ceilings is as valid as a floor plus a ceiling. When a result strobe arrives with the watchdog flag set, both limits are compared against the signed result. Every tripped limit sets its own bit in a limit status register, indexed by the instruction that produced the result.

A separate interrupt status register collects the limit-crossing event and up to six more event pulses from the sequencer and the result buffer. Status bits are sticky and record every event, whatever the interrupt mask says. The mask only gates the single active-high interrupt line. The host reads either register through a small read port, and each read clears the register it returns.

Top module: `wdog_irq_status`

## Requirements
- R1: A limit whose direction bit is 1 (ceiling) trips only when the signed result is strictly greater than the limit; an equal result does not trip it.
- R2: A limit whose direction bit is 0 (floor) trips only when the signed result is strictly less than the limit, using two's-complement comparison.
- R3: The two limits of an instruction take their directions independently; two floors or two ceilings each evaluate on their own.
- R4: On the clock edge that samples `res_valid` and `res_watch` both high, limit A of instruction i sets `lim_status` bit 2*i and limit B sets bit 2*i+1. Without both strobes, a result changes no status bit.
- R5: Interrupt status bit 0 is set by any limit trip. Bit k (k at least 1) is set by `evt_in[k-1]`, in the cycle after the pulse.
- R6: Status bits are set whether or not the matching bit of `irq_en` is set.
- R7: `irq_out` is high, with no added register stage, exactly when some bit is set in both `irq_status` and `irq_en`.
- R8: With `rd_en` high, `rd_data` shows `irq_status` when `rd_sel`=0 and `lim_status` when `rd_sel`=1, zero-extended. The register read is cleared at that edge and the other register is left unchanged. With `rd_en` low, `rd_data` is zero.
- R9: A condition that arrives in the same cycle as the clearing read leaves its bit set after the read.
- R10: After reset both status registers are zero and `irq_out` is low.
- R11: A set status bit stays set until a read of its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_watch | input | 1 | Result was taken by a watchdog-mode instruction |
| res_data | input | DATA_W | Signed conversion result |
| instr_idx | input | IDX_W | Index of the instruction that produced the result |
| lim_a | input | DATA_W | First limit word, signed |
| lim_a_hi | input | 1 | Direction of limit A: 1 ceiling, 0 floor |
| lim_b | input | DATA_W | Second limit word, signed |
| lim_b_hi | input | 1 | Direction of limit B: 1 ceiling, 0 floor |
| evt_in | input | NUM_SRC-1 | Event pulses for interrupt status bits 1 and up |
| irq_en | input | NUM_SRC | Interrupt enable mask |
| rd_en | input | 1 | Host read strobe, clears the selected register |
| rd_sel | input | 1 | 0 interrupt status, 1 limit status |
| rd_data | output | RD_W | Read data |
| irq_status | output | NUM_SRC | Interrupt status register |
| lim_status | output | 2*2**IDX_W | Limit status register |
| irq_out | output | 1 | Active-high interrupt line |

## Verification
Both status registers change on the first rising edge that samples a strobe, an event pulse or a read. `irq_out` and `rd_data` follow the registers and inputs in the same cycle. The bench drives inputs on the falling edge and checks register results at the next falling edge, one edge later. It checks `rd_data` and `irq_out` a short delay after the falling edge where their inputs change. Same-cycle collisions of a read with a new condition are driven on a single falling edge, so the read and the set meet on one rising edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic {
      LIM_FLOOR = 1'b0,
      LIM_CEIL  = 1'b1
   } lim_dir_e;

   localparam int NUM_LIMITS = 2;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wdog_limit_cmp.sv
module wdog_limit_cmp
   import wdog_pkg::*;
#(
   parameter int DATA_W = 13
) (
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] limit,
   input  lim_dir_e          dir,
   output logic              trip
);
   logic signed [DATA_W-1:0] s_val;
   logic signed [DATA_W-1:0] l_val;

   always_comb begin
      s_val = sample;
      l_val = limit;
      if (dir == LIM_CEIL) trip = (s_val > l_val);
      else                 trip = (s_val < l_val);
   end
endmodule

// File: rtl/wdog_sticky_reg.sv
module wdog_sticky_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (clr_i ? '0 : q) | set_i;
   end
endmodule

// File: rtl/wdog_irq_status.sv
module wdog_irq_status
   import wdog_pkg::*;
#(
   parameter int DATA_W  = 13,
   parameter int IDX_W   = 3,
   parameter int NUM_SRC = 7,
   localparam int NUM_INSTR = 1 << IDX_W,
   localparam int LIM_W     = 2 * NUM_INSTR,
   localparam int RD_W      = max_int(LIM_W, NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               res_valid,
   input  logic               res_watch,
   input  logic [DATA_W-1:0]  res_data,
   input  logic [IDX_W-1:0]   instr_idx,
   input  logic [DATA_W-1:0]  lim_a,
   input  logic               lim_a_hi,
   input  logic [DATA_W-1:0]  lim_b,
   input  logic               lim_b_hi,
   input  logic [NUM_SRC-2:0] evt_in,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic               rd_en,
   input  logic               rd_sel,
   output logic [RD_W-1:0]    rd_data,
   output logic [NUM_SRC-1:0] irq_status,
   output logic [LIM_W-1:0]   lim_status,
   output logic               irq_out
);
   // elaboration-time parameter checks
   if (DATA_W < 2)                 $error("DATA_W must be at least 2");
   if (IDX_W < 1 || IDX_W > 5)     $error("IDX_W must lie in 1..5");
   if (NUM_SRC < 2 || NUM_SRC > 16) $error("NUM_SRC must lie in 2..16");

   logic [DATA_W-1:0]        lim_word [NUM_LIMITS];
   lim_dir_e                 lim_dir  [NUM_LIMITS];
   logic [NUM_LIMITS-1:0]    trip;
   logic                     hit;
   logic [LIM_W-1:0]         lim_set;
   logic [NUM_SRC-1:0]       irq_set;
   logic                     clr_irq;
   logic                     clr_lim;

   assign lim_word[0] = lim_a;
   assign lim_word[1] = lim_b;
   assign lim_dir[0]  = lim_dir_e'(lim_a_hi);
   assign lim_dir[1]  = lim_dir_e'(lim_b_hi);

   for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_cmp
      wdog_limit_cmp #(.DATA_W(DATA_W)) i_cmp (
         .sample (res_data),
         .limit  (lim_word[g]),
         .dir    (lim_dir[g]),
         .trip   (trip[g])
      );
   end

   assign hit = res_valid & res_watch;

   always_comb begin
      lim_set = '0;
      if (hit) lim_set[{instr_idx, 1'b0} +: NUM_LIMITS] = trip;
   end

   assign irq_set[0]         = hit & (|trip);
   assign irq_set[NUM_SRC-1:1] = evt_in;

   assign clr_irq = rd_en & ~rd_sel;
   assign clr_lim = rd_en &  rd_sel;

   wdog_sticky_reg #(.W(NUM_SRC)) i_irq_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (irq_set),
      .clr_i (clr_irq),
      .q     (irq_status)
   );

   wdog_sticky_reg #(.W(LIM_W)) i_lim_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lim_set),
      .clr_i (clr_lim),
      .q     (lim_status)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (rd_sel) rd_data = RD_W'(lim_status);
         else        rd_data = RD_W'(irq_status);
      end
   end

   assign irq_out = |(irq_status & irq_en);
endmodule

// File: rtl/wdog_irq_status_chk.sv
module wdog_irq_status_chk #(
   parameter int DATA_W  = 13,
   parameter int IDX_W   = 3,
   parameter int NUM_SRC = 7,
   localparam int LIM_W  = 2 * (1 << IDX_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               res_valid,
   input logic               res_watch,
   input logic [DATA_W-1:0]  res_data,
   input logic [IDX_W-1:0]   instr_idx,
   input logic [DATA_W-1:0]  lim_a,
   input logic               lim_a_hi,
   input logic [DATA_W-1:0]  lim_b,
   input logic               lim_b_hi,
   input logic [NUM_SRC-2:0] evt_in,
   input logic [NUM_SRC-1:0] irq_en,
   input logic               rd_en,
   input logic               rd_sel,
   input logic [NUM_SRC-1:0] irq_status,
   input logic [LIM_W-1:0]   lim_status,
   input logic               irq_out
);
   assert_ceil_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_watch && lim_a_hi && ($signed(res_data) > $signed(lim_a)))
      |=> lim_status[{$past(instr_idx), 1'b0}]);

   assert_floor_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_watch && !lim_b_hi && ($signed(res_data) < $signed(lim_b)))
      |=> (lim_status[{$past(instr_idx), 1'b1}] && irq_status[0]));

   assert_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(res_valid && res_watch) && !rd_en) |=> $stable(lim_status));

   assert_mask_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in[0] && !irq_en[1]) |=> irq_status[1]);

   assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_en == '0) || (irq_status == '0)) |-> !irq_out);

   assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_sel && !res_valid && (evt_in == '0)) |=> (irq_status == '0));

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && !rd_sel) |=> ((irq_status & $past(irq_status)) == $past(irq_status)));
endmodule

bind wdog_irq_status wdog_irq_status_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_SRC(NUM_SRC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_watch(res_watch),
   .res_data(res_data), .instr_idx(instr_idx), .lim_a(lim_a), .lim_a_hi(lim_a_hi),
   .lim_b(lim_b), .lim_b_hi(lim_b_hi), .evt_in(evt_in), .irq_en(irq_en),
   .rd_en(rd_en), .rd_sel(rd_sel), .irq_status(irq_status),
   .lim_status(lim_status), .irq_out(irq_out)
);

// File: tb/test_wdog_irq_status.sv
module test_wdog_irq_status;
   localparam int DW = 13;
   localparam int IW = 3;
   localparam int NS = 7;
   localparam int LW = 16;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          res_valid = 1'b0;
   logic          res_watch = 1'b0;
   logic [DW-1:0] res_data = '0;
   logic [IW-1:0] instr_idx = '0;
   logic [DW-1:0] lim_a = '0;
   logic          lim_a_hi = 1'b0;
   logic [DW-1:0] lim_b = '0;
   logic          lim_b_hi = 1'b0;
   logic [NS-2:0] evt_in = '0;
   logic [NS-1:0] irq_en = '0;
   logic          rd_en = 1'b0;
   logic          rd_sel = 1'b0;
   logic [RW-1:0] rd_data;
   logic [NS-1:0] irq_status;
   logic [LW-1:0] lim_status;
   logic          irq_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdog_irq_status #(.DATA_W(DW), .IDX_W(IW), .NUM_SRC(NS)) i_wdog_irq_status (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_watch(res_watch),
      .res_data(res_data), .instr_idx(instr_idx), .lim_a(lim_a), .lim_a_hi(lim_a_hi),
      .lim_b(lim_b), .lim_b_hi(lim_b_hi), .evt_in(evt_in), .irq_en(irq_en),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_status(irq_status),
      .lim_status(lim_status), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one result for one cycle; results are due at the following falling edge
   task automatic convert(input int idx, input int data, input int la, input bit la_hi,
                          input int lb, input bit lb_hi, input bit watch);
      @(negedge clk);
      instr_idx = IW'(idx);
      res_data  = DW'(data);
      lim_a     = DW'(la);
      lim_a_hi  = la_hi;
      lim_b     = DW'(lb);
      lim_b_hi  = lb_hi;
      res_watch = watch;
      res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
      res_watch = 1'b0;
   endtask

   // host read: returns read data sampled before the clearing edge
   task automatic host_read(input bit sel, output logic [RW-1:0] data);
      @(negedge clk);
      rd_sel = sel;
      rd_en  = 1'b1;
      #1 data = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic clear_all();
      logic [RW-1:0] d;
      host_read(1'b0, d);
      host_read(1'b1, d);
   endtask

   task automatic t_reset();
      check("R10 irq_status", 32'(irq_status), 0);
      check("R10 lim_status", 32'(lim_status), 0);
      check("R10 irq_out", 32'(irq_out), 0);
      check("R8 rd_data idle", 32'(rd_data), 0);
   endtask

   task automatic t_ceiling();
      logic [RW-1:0] d;
      convert(2, 101, 100, 1'b1, -2000, 1'b0, 1'b1);
      check("R1 ceiling trip", 32'(lim_status), 32'h10);
      check("R5 limit event", 32'(irq_status), 32'h1);
      host_read(1'b1, d);
      check("R8 read lim", 32'(d), 32'h10);
      check("R8 lim cleared", 32'(lim_status), 0);
      check("R8 irq untouched", 32'(irq_status), 32'h1);
      host_read(1'b0, d);
      check("R8 read irq", 32'(d), 32'h1);
      check("R8 irq cleared", 32'(irq_status), 0);
      convert(2, 100, 100, 1'b1, -2000, 1'b0, 1'b1);
      check("R1 equal no trip", 32'(lim_status), 0);
      check("R1 equal no event", 32'(irq_status), 0);
   endtask

   task automatic t_floor();
      convert(5, -51, 4000, 1'b1, 5, 1'b0, 1'b1);
      check("R2 signed floor trip", 32'(lim_status), 32'h800);
      clear_all();
      convert(5, -50, 4000, 1'b1, -50, 1'b0, 1'b1);
      check("R2 equal no trip", 32'(lim_status), 0);
   endtask

   task automatic t_pairs();
      convert(7, 15, 10, 1'b1, 20, 1'b1, 1'b1);
      check("R3 two ceilings one", 32'(lim_status), 32'h4000);
      convert(7, 25, 10, 1'b1, 20, 1'b1, 1'b1);
      check("R3 two ceilings both", 32'(lim_status), 32'hC000);
      clear_all();
      convert(0, -15, -10, 1'b0, -20, 1'b0, 1'b1);
      check("R3 two floors one", 32'(lim_status), 32'h1);
      clear_all();
   endtask

   task automatic t_no_watch();
      convert(3, 500, 10, 1'b1, 20, 1'b1, 1'b0);
      check("R4 no watch lim", 32'(lim_status), 0);
      check("R4 no watch irq", 32'(irq_status), 0);
      @(negedge clk);
      instr_idx = 3'd3; res_data = DW'(500); res_watch = 1'b1; res_valid = 1'b0;
      @(negedge clk);
      res_watch = 1'b0;
      check("R4 no valid lim", 32'(lim_status), 0);
   endtask

   task automatic t_events_mask();
      @(negedge clk);
      irq_en = '0;
      evt_in = 6'b000100;
      @(negedge clk);
      evt_in = '0;
      check("R6 masked set", 32'(irq_status), 32'h8);
      check("R7 masked line", 32'(irq_out), 0);
      irq_en = 7'h08;
      #1 check("R7 enabled line", 32'(irq_out), 1);
      irq_en = 7'h77;
      #1 check("R7 other bits", 32'(irq_out), 0);
      irq_en = '0;
      repeat (5) @(negedge clk);
      check("R11 sticky", 32'(irq_status), 32'h8);
   endtask

   task automatic t_collide();
      logic [RW-1:0] d;
      // read interrupt status while a new event arrives in the same cycle
      @(negedge clk);
      evt_in = 6'b000001;
      rd_sel = 1'b0;
      rd_en  = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      evt_in = '0;
      rd_en  = 1'b0;
      check("R8 collide data", 32'(d), 32'h8);
      check("R9 set survives", 32'(irq_status), 32'h2);
      // read limit status while a trip on instruction 1 arrives
      convert(4, 50, 10, 1'b1, 0, 1'b0, 1'b1);
      @(negedge clk);
      instr_idx = 3'd1; res_data = DW'(-9); lim_a = DW'(100); lim_a_hi = 1'b1;
      lim_b = DW'(-8); lim_b_hi = 1'b0; res_watch = 1'b1; res_valid = 1'b1;
      rd_sel = 1'b1; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      res_valid = 1'b0; res_watch = 1'b0; rd_en = 1'b0;
      check("R8 lim collide data", 32'(d), 32'h100);
      check("R9 lim survives", 32'(lim_status), 32'h8);
      clear_all();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ceiling();
      t_floor();
      t_pairs();
      t_no_watch();
      t_events_mask();
      t_collide();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule